// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Stop-Bit Checking

This block receives asynchronous serial frames from an already-synchronised RX line. An external baud generator supplies `sampleTick`, an enable that pulses OVERSAMPLE times per bit period. The receiver looks for a falling edge on the idle-high line. It confirms the start bit at mid-bit, then samples eight data bits at mid-bit and checks one or two stop bits. The bit order of the data field is set by a configuration input.

A frame is one start bit (low), DATA_W data bits, and one or two stop bits (high). Completion is reported through a held byte-ready flag and a one-cycle interrupt pulse gated by an enable input. When two stop bits are configured, completion is signalled as soon as the first stop bit proves good. The result of the second stop bit comes one bit period later: the framing-error flag is set then, and the active indication ends at the same point. Software clears the sticky flags with a status-read strobe.

Top module: `async_rx`

## Requirements
- R1: After reset, `byteReady`, `frameErr`, `active` and `irq` are 0 and `rxData` is 0.
- R2: A start bit is accepted only if the line is still low at the mid-bit sample, HALF = OVERSAMPLE/2 ticks after the falling edge. Otherwise the receiver returns to idle and sets no flag.
- R3: Data bits are sampled every OVERSAMPLE ticks at mid-bit. With `msbFirst`=0 the first data bit received becomes `rxData[0]`. With `msbFirst`=1 it becomes `rxData[7]`.
- R4: With `twoStop`=0, only one stop bit is checked. When that stop bit is high, `byteReady` rises and `active` falls on the same clock edge.
- R5: With `twoStop`=1, `byteReady` rises at the first good stop bit, and `active` falls exactly OVERSAMPLE ticks later, at the second stop bit's sample.
- R6: With `twoStop`=1, a low second stop bit sets `frameErr` exactly OVERSAMPLE ticks after `byteReady` rose. `byteReady` and `rxData` stay valid.
- R7: A low first stop bit sets `frameErr`, leaves `byteReady` low, raises no `irq` and leaves `rxData` unchanged. The frame then ends.
- R8: `rxData` holds the received byte on the same edge on which `byteReady` rises.
- R9: `irq` is a one-cycle pulse coincident with the rise of `byteReady`, and it is raised only when `intEnable` is 1.
- R10: `byteReady` and `frameErr` stay set until `statusRead` is pulsed. A pulse clears both, unless a new set arrives in the same cycle, in which case the set wins.
- R11: `active` goes high on the edge after a falling edge is seen in idle, and it stays high through the whole frame.
- R12: A new frame starts only on a high-to-low transition. A line that stays low after a framing error does not restart the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Synchronised serial input, idles high |
| sampleTick | input | 1 | Oversampling enable, OVERSAMPLE pulses per bit |
| twoStop | input | 1 | 1 = check two stop bits, 0 = one |
| msbFirst | input | 1 | 1 = data arrives MSB first, 0 = LSB first |
| intEnable | input | 1 | Gates the receive interrupt |
| statusRead | input | 1 | Status-read strobe, clears byteReady and frameErr |
| rxData | output | DATA_W | Received data buffer |
| byteReady | output | 1 | Sticky byte-received flag |
| active | output | 1 | High while a frame is in progress |
| frameErr | output | 1 | Sticky framing-error flag |
| irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The assertions check the following on every cycle:
- a completion strobe always finds the line high and is followed by `byteReady`;
- completion and framing error never coincide;
- `irq` only appears with `byteReady` and a set enable;
- a status read with no competing set clears both flags;
- a falling edge seen in idle raises `active`.

Other behaviour can only be shown by the bench's scenarios:
- the bit-order mapping of every byte value;
- the one-bit-period spacing between completion and the later framing-error or end-of-active events;
- the rejection of a short start glitch;
- the refusal to restart on a stuck-low line.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP1,
    ST_STOP2
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic commit;
    logic markFe;
  } rxStrobes_t;

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       startEdge,
  input  logic       twoStop,
  output rxStrobes_t strobes,
  output logic       active
);

  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int HALF  = OVERSAMPLE / 2;

  rxState_t   state, stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic       midPoint;
  logic       cntClear;

  always_comb begin
    if (state == ST_START)
      midPoint = sampleTick && (tickCnt == CNT_W'(HALF - 1));
    else
      midPoint = sampleTick && (tickCnt == CNT_W'(OVERSAMPLE - 1));
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    cntClear  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startEdge) begin
          stateNext = ST_START;
          cntClear  = 1'b1;
        end
      end
      ST_START: begin
        if (midPoint) stateNext = rxLine ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        if (midPoint) begin
          strobes.shiftEn = 1'b1;
          if (bitCnt == BIT_W'(DATA_W - 1)) stateNext = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (midPoint) begin
          if (rxLine) begin
            strobes.commit = 1'b1;
            stateNext      = twoStop ? ST_STOP2 : ST_IDLE;
          end else begin
            strobes.markFe = 1'b1;
            stateNext      = ST_IDLE;
          end
        end
      end
      ST_STOP2: begin
        if (midPoint) begin
          strobes.markFe = !rxLine;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state <= stateNext;
      if (cntClear || midPoint) tickCnt <= '0;
      else if (sampleTick)      tickCnt <= tickCnt + 1'b1;
      if (state != ST_DATA)     bitCnt  <= '0;
      else if (midPoint)        bitCnt  <= bitCnt + 1'b1;
    end
  end

  assign active = (state != ST_IDLE);

  // R4: completion only happens with a high stop-bit sample
  assert_commit_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> rxLine);

  // R7: completion and framing error are exclusive
  assert_commit_fe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.commit && strobes.markFe));

  // R11: an edge seen in idle starts a frame
  assert_active_on_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    (startEdge && !active) |=> active);

endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              msbFirst,
  input  logic              intEnable,
  input  logic              statusRead,
  input  rxStrobes_t        strobes,
  output logic              startEdge,
  output logic [DATA_W-1:0] rxData,
  output logic              byteReady,
  output logic              frameErr,
  output logic              irq
);

  logic              prevLine;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;

  assign startEdge = prevLine && !rxLine;

  always_comb begin
    if (msbFirst) shiftNext = {shiftReg[DATA_W-2:0], rxLine};
    else          shiftNext = {rxLine, shiftReg[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine  <= 1'b1;
      shiftReg  <= '0;
      rxData    <= '0;
      byteReady <= 1'b0;
      frameErr  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      prevLine <= rxLine;
      irq      <= strobes.commit && intEnable;
      if (strobes.shiftEn) shiftReg <= shiftNext;
      if (strobes.commit) begin
        rxData    <= shiftReg;
        byteReady <= 1'b1;
      end else if (statusRead) begin
        byteReady <= 1'b0;
      end
      if (strobes.markFe)  frameErr <= 1'b1;
      else if (statusRead) frameErr <= 1'b0;
    end
  end

  // R8: a completion strobe leaves the ready flag set
  assert_ready_after_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> byteReady);

  // R6: a framing strobe leaves the error flag set
  assert_fe_after_mark_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markFe |=> frameErr);

  // R9: interrupt only with ready and enable
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (byteReady && $past(intEnable)));

  // R10: status read with no competing set clears both flags
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !strobes.commit && !strobes.markFe) |=> (!byteReady && !frameErr));

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  input  logic              twoStop,
  input  logic              msbFirst,
  input  logic              intEnable,
  input  logic              statusRead,
  output logic [DATA_W-1:0] rxData,
  output logic              byteReady,
  output logic              active,
  output logic              frameErr,
  output logic              irq
);

  rxStrobes_t strobes;
  logic       startEdge;

  async_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .startEdge(startEdge), .twoStop(twoStop), .strobes(strobes), .active(active)
  );

  async_rx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .msbFirst(msbFirst),
    .intEnable(intEnable), .statusRead(statusRead), .strobes(strobes),
    .startEdge(startEdge), .rxData(rxData), .byteReady(byteReady),
    .frameErr(frameErr), .irq(irq)
  );

endmodule

// File: tb/sim_async_rx.sv
module sim_async_rx;
  localparam int OVS  = 4;
  localparam int BITC = OVS * 2;  // tick every second clock

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1, sampleTick = 1'b0, twoStop = 1'b0, msbFirst = 1'b0;
  logic intEnable = 1'b0, statusRead = 1'b0;
  logic [7:0] rxData;
  logic byteReady, active, frameErr, irq;

  int errors = 0, checks = 0, cyc = 0;
  int readyCyc, feCyc, fallCyc, irqCnt;
  logic prevReady = 0, prevFe = 0, prevAct = 0;
  logic activeMid, stuckActive;
  logic [7:0] lastGood = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  async_rx #(.OVERSAMPLE(OVS), .DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .twoStop(twoStop), .msbFirst(msbFirst), .intEnable(intEnable),
    .statusRead(statusRead), .rxData(rxData), .byteReady(byteReady),
    .active(active), .frameErr(frameErr), .irq(irq)
  );

  always @(negedge clk) begin
    cyc++;
    sampleTick <= ~sampleTick;
    if (byteReady && !prevReady) readyCyc = cyc;
    if (frameErr && !prevFe)     feCyc = cyc;
    if (!active && prevAct)      fallCyc = cyc;
    if (irq) irqCnt++;
    prevReady = byteReady; prevFe = frameErr; prevAct = active;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic msb, input logic two,
                           input logic s1, input logic s2, input logic ie, input int holdLow);
    @(negedge clk);
    msbFirst = msb; twoStop = two; intEnable = ie;
    irqCnt = 0; readyCyc = -1; feCyc = -1; fallCyc = -1;
    rxLine = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = msb ? b[7-i] : b[i];
      repeat (BITC) @(negedge clk);
      if (i == 3) activeMid = active;
    end
    rxLine = s1;
    repeat (BITC) @(negedge clk);
    if (!s1) begin
      repeat (holdLow * BITC) @(negedge clk);
      stuckActive = active;
    end else if (two) begin
      rxLine = s2;
      repeat (BITC) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic readStatus();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    chk(!byteReady && !frameErr, "R10 cleared", {byteReady, frameErr}, 0);
  endtask

  task automatic goodFrame(input logic [7:0] b, input logic msb, input logic two, input logic ie);
    sendFrame(b, msb, two, 1'b1, 1'b1, ie, 0);
    chk(rxData == b, msb ? "R3 msb data" : "R3 lsb data", rxData, b);
    chk(byteReady && !frameErr, "R8 ready", {byteReady, frameErr}, 2);
    chk(irqCnt == int'(ie), "R9 irq count", irqCnt, int'(ie));
    chk(activeMid, "R11 active mid", activeMid, 1);
    if (two) chk(fallCyc - readyCyc == BITC, "R5 active fall", fallCyc - readyCyc, BITC);
    else     chk(fallCyc - readyCyc == 0, "R4 active fall", fallCyc - readyCyc, 0);
    lastGood = b;
    readStatus();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!byteReady && !frameErr && !active && !irq && rxData == 0, "R1 reset",
        {byteReady, frameErr, active, irq}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5 R8 R9: sweep all bytes, both orders, both stop modes
    for (int two = 0; two < 2; two++)
      for (int msb = 0; msb < 2; msb++)
        for (int b = 0; b < 256; b++)
          goodFrame(8'(b), msb[0], two[0], b[0] ^ b[3]);

    // R6: bad second stop bit
    for (int msb = 0; msb < 2; msb++) begin
      sendFrame(8'hA5, msb[0], 1'b1, 1'b1, 1'b0, 1'b1, 0);
      chk(byteReady && rxData == 8'hA5, "R6 data kept", rxData, 8'hA5);
      chk(frameErr, "R6 fe set", frameErr, 1);
      chk(feCyc - readyCyc == BITC, "R6 fe delay", feCyc - readyCyc, BITC);
      chk(fallCyc == feCyc, "R5 fall at second stop", fallCyc, feCyc);
      chk(irqCnt == 1, "R9 irq on first stop", irqCnt, 1);
      chk(byteReady && frameErr, "R10 held", {byteReady, frameErr}, 3);
      lastGood = 8'hA5;
      readStatus();
    end

    // R7: bad first stop bit, both modes
    for (int two = 0; two < 2; two++) begin
      sendFrame(8'h3C, 1'b0, two[0], 1'b0, 1'b1, 1'b1, 0);
      chk(!byteReady && frameErr, "R7 flags", {byteReady, frameErr}, 1);
      chk(irqCnt == 0, "R7 no irq", irqCnt, 0);
      chk(rxData == lastGood, "R7 data unchanged", rxData, lastGood);
      readStatus();
    end

    // R12: line stays low after framing error
    sendFrame(8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4);
    chk(!stuckActive, "R12 no restart", stuckActive, 0);
    chk(!byteReady && frameErr, "R12 flags", {byteReady, frameErr}, 1);
    readStatus();

    // R2: short start glitch rejected
    @(negedge clk);
    rxLine = 1'b0;
    @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    chk(!active && !byteReady && !frameErr, "R2 glitch", {active, byteReady, frameErr}, 0);
    goodFrame(8'h81, 1'b1, 1'b0, 1'b1);

    // R9: interrupt disabled
    goodFrame(8'h42, 1'b0, 1'b1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule